// File: doc/BRIEF.md
# Translator Configuration Register Bank

This block is the software-visible register bank that sits beside a DMA address translator. It holds the translator's enable bit, the size of the translated address window, the physical base of the page table and a few arbitration and per-slot setup words. Every register applies its own write mask, and several of them force some bits to fixed values. A CPU reaches the bank through a simple request bus that carries 32-bit word accesses. The register index is the byte offset shifted right by two. A read returns its data one cycle after it is accepted.

The translator reports a failed lookup through a single-cycle fault strobe. That strobe loads the fault status and fault address registers and raises a level interrupt. Software lowers the interrupt by reading or writing either fault register. The bank also turns the three-bit range code into the start address of the translated window, which always ends at the top of the 32-bit space. It drives that start address to the translator as a registered value.

Top module: `xlat_cfg_regfile`

## Requirements
- R1: After reset the registers hold these values: control = IMPL_VER<<24, arbitration enable (0x2000) = 0x00000008, fault status (0x1000) = 0x00800000, arbiter enable (0x1008) = 0x00000003, mask ID (0x3018) = 0x23000000. Every other register holds zero. win_base, xlat_enable and irq are all 0.
- R2: A write to control (0x0000) stores (data & 0x1D) | (IMPL_VER<<24). Bit 0 is the enable and appears on xlat_enable.
- R3: Bits [4:2] of a control write form a range code c. From the next cycle win_base = 0xFFFFFFFF << (24+c), truncated to 32 bits. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. win_base changes only on a control write.
- R4: The page table base register (0x0004) keeps data & 0x07FFFC00, and pt_base shows it. The flush words at 0x0014 and 0x0018 store the full value. Any other offset ignores writes and reads as zero.
- R5: A software write to fault status stores (data & 0xFF0FFFFF) | 0x00800000. A write to fault address (0x1004) stores the full value.
- R6: The arbiter enable register keeps (data & 0x801F000F) | 1. Each of the NUM_SLOTS slot words at 0x1010 + 4*i keeps data & 0x00010003. The arbitration enable register keeps (data & 0x001F0000) | 0x8.
- R7: A write to mask ID ORs data[23:0] into the stored value, so its bits can only be set.
- R8: A fault strobe loads fault status with 0xC0820000, plus 0x00040000 when flt_read is 1. It loads fault address with flt_addr with bits [11:0] cleared. A fault beats a software write to either register in the same cycle.
- R9: irq is 1 in the cycle after a fault strobe. Any read or write of 0x1000 or 0x1004 without a fault in the same cycle makes irq 0 in the next cycle. Any other access leaves irq unchanged.
- R10: req_ready is always 1. Every read gives rsp_valid = 1 one cycle later, with rsp_rdata equal to the register value before any same-cycle update. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Translator fault strobe |
| flt_read | input | 1 | Faulting access was a read |
| flt_addr | input | 32 | Faulting address |
| irq | output | 1 | Level fault interrupt |
| xlat_enable | output | 1 | Translator enable |
| win_base | output | 32 | Start of translated window |
| pt_base | output | 32 | Page table base register value |

## Verification
The assertions assume two things about the bus. Every byte offset is word aligned. The fault strobe lasts a single cycle per fault, and a fault may coincide with any bus access, including an access to the fault registers. The bench issues only aligned offsets and pulses the strobe for one cycle. In one case it deliberately lines a fault up with a software write to fault status, which exercises the priority rule and the interrupt-hold rule together.

// File: rtl/xlat_cfg_pkg.sv
package xlat_cfg_pkg;

    localparam int WORD_W = 32;

    // word indices (byte offset >> 2)
    localparam int IX_CTRL       = 'h000;
    localparam int IX_PTBASE     = 'h001;
    localparam int IX_FLUSH_ALL  = 'h005;
    localparam int IX_FLUSH_PAGE = 'h006;
    localparam int IX_FSTAT      = 'h400;
    localparam int IX_FADDR      = 'h401;
    localparam int IX_ARB        = 'h402;
    localparam int IX_SLOT0      = 'h404;
    localparam int IX_ARBEN      = 'h800;
    localparam int IX_MASKID     = 'hC06;

    // write masks and forced-one bits
    localparam logic [WORD_W-1:0] CTRL_KEEP   = 32'h0000_001D;
    localparam logic [WORD_W-1:0] PTBASE_KEEP = 32'h07FF_FC00;
    localparam logic [WORD_W-1:0] FSTAT_KEEP  = 32'hFF0F_FFFF;
    localparam logic [WORD_W-1:0] FSTAT_ONE   = 32'h0080_0000;
    localparam logic [WORD_W-1:0] ARB_KEEP    = 32'h801F_000F;
    localparam logic [WORD_W-1:0] ARB_ONE     = 32'h0000_0001;
    localparam logic [WORD_W-1:0] ARB_RST     = 32'h0000_0003;
    localparam logic [WORD_W-1:0] SLOT_KEEP   = 32'h0001_0003;
    localparam logic [WORD_W-1:0] ARBEN_KEEP  = 32'h001F_0000;
    localparam logic [WORD_W-1:0] ARBEN_ONE   = 32'h0000_0008;
    localparam logic [WORD_W-1:0] MASKID_KEEP = 32'h00FF_FFFF;
    localparam logic [WORD_W-1:0] MASKID_RST  = 32'h2300_0000;

    // fault status bits set by the translator
    localparam logic [WORD_W-1:0] FS_ANY    = 32'h8000_0000;
    localparam logic [WORD_W-1:0] FS_LATE   = 32'h4000_0000;
    localparam logic [WORD_W-1:0] FS_RD     = 32'h0004_0000;
    localparam logic [WORD_W-1:0] FS_AVALID = 32'h0002_0000;

    localparam int PAGE_BITS = 12;

    typedef struct packed {
        logic ctrl;
        logic ptbase;
        logic flush_all;
        logic flush_page;
        logic fstat;
        logic faddr;
        logic arb;
        logic arben;
        logic maskid;
    } sel_t;

    typedef struct packed {
        logic              hit;
        logic              is_read;
        logic [WORD_W-1:0] addr;
    } fault_t;

    function automatic logic [WORD_W-1:0] win_base_of(input logic [2:0] code);
        return 32'hFFFF_FFFF << (5'd24 + {2'b00, code});
    endfunction

    function automatic logic [WORD_W-1:0] fault_word(input logic is_read);
        return FS_ANY | FS_LATE | FSTAT_ONE | FS_AVALID | (is_read ? FS_RD : '0);
    endfunction

endpackage

// File: rtl/xlat_cfg_decode.sv
module xlat_cfg_decode
    import xlat_cfg_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_SLOTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output sel_t                 sel,
    output logic [NUM_SLOTS-1:0] slot_sel,
    output logic                 fault_hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    int               idx_i;

    assign idx   = addr[ADDR_W-1:2];
    assign idx_i = int'(idx);

    assign sel.ctrl       = (idx_i == IX_CTRL);
    assign sel.ptbase     = (idx_i == IX_PTBASE);
    assign sel.flush_all  = (idx_i == IX_FLUSH_ALL);
    assign sel.flush_page = (idx_i == IX_FLUSH_PAGE);
    assign sel.fstat      = (idx_i == IX_FSTAT);
    assign sel.faddr      = (idx_i == IX_FADDR);
    assign sel.arb        = (idx_i == IX_ARB);
    assign sel.arben      = (idx_i == IX_ARBEN);
    assign sel.maskid     = (idx_i == IX_MASKID);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_dec
        assign slot_sel[g] = (idx_i == IX_SLOT0 + g);
    end

    assign fault_hit = sel.fstat | sel.faddr;
endmodule

// File: rtl/xlat_cfg_ctrl.sv
module xlat_cfg_ctrl
    import xlat_cfg_pkg::*;
#(
    parameter logic [7:0] IMPL_VER = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  sel_t              sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] win_q,
    output logic [WORD_W-1:0] ptbase_q,
    output logic [WORD_W-1:0] flush_all_q,
    output logic [WORD_W-1:0] flush_page_q,
    output logic [WORD_W-1:0] arb_q,
    output logic [WORD_W-1:0] arben_q,
    output logic [WORD_W-1:0] maskid_q
);
    localparam logic [WORD_W-1:0] VER_WORD = {IMPL_VER, 24'h0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= VER_WORD;
            win_q        <= '0;
            ptbase_q     <= '0;
            flush_all_q  <= '0;
            flush_page_q <= '0;
            arb_q        <= ARB_RST;
            arben_q      <= ARBEN_ONE;
            maskid_q     <= MASKID_RST;
        end else if (we) begin
            if (sel.ctrl) begin
                ctrl_q <= (wdata & CTRL_KEEP) | VER_WORD;
                win_q  <= win_base_of(wdata[4:2]);
            end
            if (sel.ptbase)     ptbase_q     <= wdata & PTBASE_KEEP;
            if (sel.flush_all)  flush_all_q  <= wdata;
            if (sel.flush_page) flush_page_q <= wdata;
            if (sel.arb)        arb_q        <= (wdata & ARB_KEEP) | ARB_ONE;
            if (sel.arben)      arben_q      <= (wdata & ARBEN_KEEP) | ARBEN_ONE;
            if (sel.maskid)     maskid_q     <= maskid_q | (wdata & MASKID_KEEP);
        end
    end
endmodule

// File: rtl/xlat_cfg_slots.sv
module xlat_cfg_slots
    import xlat_cfg_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [NUM_SLOTS-1:0]               slot_sel,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [NUM_SLOTS-1:0][WORD_W-1:0]   slot_q
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                   slot_q[g] <= '0;
            else if (we && slot_sel[g]) slot_q[g] <= wdata & SLOT_KEEP;
        end
    end
endmodule

// File: rtl/xlat_cfg_fault.sv
module xlat_cfg_fault
    import xlat_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stat,
    input  logic              wr_addr,
    input  logic              touch,
    input  logic [WORD_W-1:0] wdata,
    input  fault_t            flt,
    output logic [WORD_W-1:0] stat_q,
    output logic [WORD_W-1:0] addr_q,
    output logic              irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= FSTAT_ONE;
            addr_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (flt.hit) begin
                stat_q <= fault_word(flt.is_read);
                addr_q <= {flt.addr[WORD_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
            end else begin
                if (wr_stat) stat_q <= (wdata & FSTAT_KEEP) | FSTAT_ONE;
                if (wr_addr) addr_q <= wdata;
            end
            if (flt.hit)    irq_q <= 1'b1;
            else if (touch) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/xlat_cfg_regfile.sv
module xlat_cfg_regfile
    import xlat_cfg_pkg::*;
#(
    parameter int         ADDR_W    = 14,
    parameter int         NUM_SLOTS = 4,
    parameter logic [7:0] IMPL_VER  = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic              flt_valid,
    input  logic              flt_read,
    input  logic [31:0]       flt_addr,
    output logic              irq,
    output logic              xlat_enable,
    output logic [31:0]       win_base,
    output logic [31:0]       pt_base
);
    sel_t                             sel;
    logic [NUM_SLOTS-1:0]             slot_sel;
    logic                             fault_hit;
    logic                             we;
    fault_t                           flt;
    logic [WORD_W-1:0]                ctrl_q, win_q, ptbase_q, flush_all_q, flush_page_q;
    logic [WORD_W-1:0]                arb_q, arben_q, maskid_q, stat_q, faddr_q;
    logic [NUM_SLOTS-1:0][WORD_W-1:0] slot_q;
    logic [WORD_W-1:0]                rd_mux;

    assign req_ready = 1'b1;
    assign we        = req_valid & req_write;
    assign flt       = '{hit: flt_valid, is_read: flt_read, addr: flt_addr};

    xlat_cfg_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr(req_addr), .sel(sel), .slot_sel(slot_sel), .fault_hit(fault_hit)
    );

    xlat_cfg_ctrl #(.IMPL_VER(IMPL_VER)) u_ctrl (
        .clk(clk), .rst(rst), .we(we), .sel(sel), .wdata(req_wdata),
        .ctrl_q(ctrl_q), .win_q(win_q), .ptbase_q(ptbase_q),
        .flush_all_q(flush_all_q), .flush_page_q(flush_page_q),
        .arb_q(arb_q), .arben_q(arben_q), .maskid_q(maskid_q)
    );

    xlat_cfg_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk(clk), .rst(rst), .we(we), .slot_sel(slot_sel),
        .wdata(req_wdata), .slot_q(slot_q)
    );

    xlat_cfg_fault u_fault (
        .clk(clk), .rst(rst),
        .wr_stat(we & sel.fstat), .wr_addr(we & sel.faddr),
        .touch(req_valid & fault_hit), .wdata(req_wdata), .flt(flt),
        .stat_q(stat_q), .addr_q(faddr_q), .irq_q(irq)
    );

    always_comb begin
        rd_mux = '0;
        if (sel.ctrl)       rd_mux = ctrl_q;
        if (sel.ptbase)     rd_mux = ptbase_q;
        if (sel.flush_all)  rd_mux = flush_all_q;
        if (sel.flush_page) rd_mux = flush_page_q;
        if (sel.fstat)      rd_mux = stat_q;
        if (sel.faddr)      rd_mux = faddr_q;
        if (sel.arb)        rd_mux = arb_q;
        if (sel.arben)      rd_mux = arben_q;
        if (sel.maskid)     rd_mux = maskid_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (slot_sel[i]) rd_mux = slot_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid & ~req_write;
            if (req_valid & ~req_write) rsp_rdata <= rd_mux;
        end
    end

    assign xlat_enable = ctrl_q[0];
    assign win_base    = win_q;
    assign pt_base     = ptbase_q;
endmodule

// File: rtl/xlat_cfg_check.sv
module xlat_cfg_check
    import xlat_cfg_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic              flt_valid,
    input logic              irq,
    input logic              xlat_enable,
    input logic [31:0]       win_base
);
    int   idx_i;
    logic fhit;
    logic ctrl_wr;
    logic rd_req;

    assign idx_i   = int'(req_addr[ADDR_W-1:2]);
    assign fhit    = req_valid && (idx_i == IX_FSTAT || idx_i == IX_FADDR);
    assign ctrl_wr = req_valid && req_write && (idx_i == IX_CTRL);
    assign rd_req  = req_valid && !req_write;

    p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |=> irq);
    p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (fhit && !flt_valid) |=> !irq);
    p_irq_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (!flt_valid && !fhit) |=> $stable(irq));
    p_rsp_read_r10: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid);
    p_enable_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (xlat_enable == $past(req_wdata[0])));
    p_win_top_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> win_base[31]);
    p_win_keep_r3: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(win_base));
endmodule

bind xlat_cfg_regfile xlat_cfg_check #(.ADDR_W(ADDR_W)) u_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .flt_valid(flt_valid), .irq(irq), .xlat_enable(xlat_enable),
    .win_base(win_base)
);

// File: tb/test_xlat_cfg_regfile.sv
`timescale 1ns/1ps
module test_xlat_cfg_regfile;
    localparam logic [7:0] VER = 8'h05;
    localparam logic [31:0] VW = {VER, 24'h0};

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_ready;
    logic [13:0] req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        flt_valid, flt_read;
    logic [31:0] flt_addr;
    logic        irq, xlat_enable;
    logic [31:0] win_base, pt_base;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    xlat_cfg_regfile #(.ADDR_W(14), .NUM_SLOTS(4), .IMPL_VER(VER)) i_xlat_cfg_regfile (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .flt_valid(flt_valid),
        .flt_read(flt_read), .flt_addr(flt_addr), .irq(irq),
        .xlat_enable(xlat_enable), .win_base(win_base), .pt_base(pt_base)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string       t;
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rsp_rdata, e);
            end
        end
    end

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fault(input logic [31:0] a, input logic is_rd);
        @(negedge clk);
        flt_valid = 1'b1; flt_read = is_rd; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    function automatic logic [31:0] win_exp(input int c);
        logic [63:0] w;
        w = 64'hFFFF_FFFF_FFFF_FFFF << (24 + c);
        return w[31:0];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        flt_valid = 1'b0; flt_read = 1'b0; flt_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 win_base", win_base, 32'd0);
        check("R1 enable", {31'd0, xlat_enable}, 32'd0);
        check("R10 ready", {31'd0, req_ready}, 32'd1);
        rd(14'h0000, VW,           "R1 control");
        rd(14'h2000, 32'h0000_0008, "R1 arbitration enable");
        rd(14'h1000, 32'h0080_0000, "R1 fault status");
        rd(14'h1008, 32'h0000_0003, "R1 arbiter enable");
        rd(14'h3018, 32'h2300_0000, "R1 mask id");
        rd(14'h0004, 32'h0,         "R1 pt base");
        rd(14'h1004, 32'h0,         "R1 fault addr");
        rd(14'h1010, 32'h0,         "R1 slot0");

        // R2 control mask and enable
        wr(14'h0000, 32'hFFFF_FFFF);
        check("R10 no response to write", {31'd0, rsp_valid}, 32'd0);
        check("R2 enable set", {31'd0, xlat_enable}, 32'd1);
        rd(14'h0000, VW | 32'h1D, "R2 control masked");
        check("R3 win code7", win_base, 32'h8000_0000);
        wr(14'h0000, 32'h0000_0000);
        check("R2 enable clear", {31'd0, xlat_enable}, 32'd0);
        check("R3 win code0", win_base, 32'hFF00_0000);

        // R3 every range code
        for (int c = 0; c < 8; c++) begin
            wr(14'h0000, 32'(c) << 2 | 32'h1);
            check("R3 window base", win_base, win_exp(c));
        end
        wr(14'h0004, 32'h1234_5678);
        check("R3 base held over other write", win_base, win_exp(7));

        // R4 page table base, flush words, unmapped
        wr(14'h0004, 32'hFFFF_FFFF);
        check("R4 pt_base port", pt_base, 32'h07FF_FC00);
        rd(14'h0004, 32'h07FF_FC00, "R4 pt base masked");
        wr(14'h0014, 32'hDEAD_BEEF);
        wr(14'h0018, 32'hCAFE_F00D);
        rd(14'h0014, 32'hDEAD_BEEF, "R4 flush all full");
        rd(14'h0018, 32'hCAFE_F00D, "R4 flush page full");
        wr(14'h0008, 32'hA5A5_A5A5);
        rd(14'h0008, 32'h0, "R4 unmapped reads zero");

        // R5 software fault register writes
        wr(14'h1000, 32'h0000_0000);
        rd(14'h1000, 32'h0080_0000, "R5 status forced bit");
        wr(14'h1000, 32'hFFFF_FFFF);
        rd(14'h1000, 32'hFF8F_FFFF, "R5 status masked");
        wr(14'h1004, 32'h1234_5678);
        rd(14'h1004, 32'h1234_5678, "R5 fault addr full");

        // R6 arbitration and slot registers
        wr(14'h1008, 32'h0);
        rd(14'h1008, 32'h0000_0001, "R6 arbiter forced bit");
        wr(14'h1008, 32'hFFFF_FFFF);
        rd(14'h1008, 32'h801F_000F, "R6 arbiter masked");
        for (int i = 0; i < 4; i++) wr(14'(14'h1010 + 4 * i), 32'hFFFF_FFF0 | 32'(i));
        for (int i = 0; i < 4; i++) rd(14'(14'h1010 + 4 * i), 32'h0001_0000 | 32'(i), "R6 slot masked");
        wr(14'h2000, 32'h0);
        rd(14'h2000, 32'h0000_0008, "R6 arbitration forced bit");
        wr(14'h2000, 32'hFFFF_FFFF);
        rd(14'h2000, 32'h001F_0008, "R6 arbitration masked");

        // R7 mask ID accumulates
        wr(14'h3018, 32'h0000_00F0);
        rd(14'h3018, 32'h2300_00F0, "R7 mask id first");
        wr(14'h3018, 32'hFF00_000F);
        rd(14'h3018, 32'h2300_00FF, "R7 mask id or");
        wr(14'h3018, 32'h0);
        rd(14'h3018, 32'h2300_00FF, "R7 mask id sticky");

        // R8 / R9 read fault, cleared by status read
        fault(32'hFF12_3ABC, 1'b1);
        check("R9 irq raised", {31'd0, irq}, 32'd1);
        rd(14'h0000, VW | 32'h1D, "R9 other read");
        check("R9 irq kept by other access", {31'd0, irq}, 32'd1);
        rd(14'h1000, 32'hC086_0000, "R8 status read fault");
        check("R9 irq cleared by status read", {31'd0, irq}, 32'd0);
        rd(14'h1004, 32'hFF12_3000, "R8 fault address");

        // write fault, cleared by fault-address write
        fault(32'h8000_4FFF, 1'b0);
        check("R9 irq raised again", {31'd0, irq}, 32'd1);
        rd(14'h1000, 32'hC082_0000, "R8 status write fault");
        fault(32'h8000_5000, 1'b0);
        wr(14'h1004, 32'h0000_0042);
        check("R9 irq cleared by addr write", {31'd0, irq}, 32'd0);
        rd(14'h1004, 32'h0000_0042, "R5 addr write after fault");

        // fault and software write in the same cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h1000; req_wdata = 32'h0;
        flt_valid = 1'b1; flt_read = 1'b1; flt_addr = 32'hC000_1234;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; flt_valid = 1'b0;
        check("R9 irq held on same-cycle clear", {31'd0, irq}, 32'd1);
        rd(14'h1000, 32'hC086_0000, "R8 fault beats software write");
        check("R9 irq cleared after", {31'd0, irq}, 32'd0);

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule